// File: doc/BRIEF.md
# SDRAM Command and Timing Controller

This block sits between a simple word-wide host port and one rank of four-bank single-data-rate SDRAM running from a 10 ns clock. After reset it waits out a stable-power period while holding no-operation on the command pins. It then closes every bank, runs two auto-refresh cycles and programs the mode register for single-word bursts in sequential order with a CAS latency of two. Only after that does it start to accept host requests.

Each host request is served under a closed-page policy. The controller opens the row, issues a read or write that carries the auto-precharge flag, and spaces the next row open far enough apart that the device has closed the bank on its own. Every spacing is derived from a nanosecond limit that is rounded up to whole clock cycles. A refresh interval counter raises a refresh request. The controller serves that request at the next idle point: it closes all banks, issues the refresh and holds the host off until the row cycle time has passed. Read data is captured CAS-latency cycles after the read command and returned with a one-cycle valid pulse.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset is released, the command pins stay at no-operation for at least INIT_WAIT cycles. The first command is then a precharge with address bit 10 high, followed by an auto-refresh exactly 2 cycles later, a second auto-refresh 7 cycles after the first, and a mode-register set 7 cycles after the second. The mode-register set carries address 0x020 (burst length code 000 in bits 2:0, sequential order bit 3 = 0, CAS latency 2 in bits 6:4) and bank 0. `req_ready` stays low for the whole sequence.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: mode set 0000, refresh 0001, activate 0011, read 0101, write 0100, precharge 0010 and no-operation 0111. Every cycle with no command is a no-operation.
- R3: An accepted request maps `req_addr[24:23]` to the bank pins and `req_addr[22:10]` to the row on the activate. It maps `req_addr[9:0]` to A9:A0 on the following read (`req_write`=0) or write (`req_write`=1), to the same bank. Read and write always carry A10 high, which requests auto-precharge.
- R4: The read or write follows its activate after exactly 2 cycles (tRCD of 20 ns), with a no-operation in between.
- R5: Two activates are at least 7 cycles apart. This covers tRC of 70 ns, tRAS plus tRP, tRRD, and write recovery followed by auto-precharge (2 cycles plus 20 ns).
- R6: No command other than no-operation is issued in the cycle that follows a mode-register set (a 2-cycle quiet period).
- R7: On a write, `sd_dq_out` carries `req_wdata` and `sd_dq_oe` is high in the write cycle only. `sd_dqm[i]` is the inverse of `req_be[i]`, where bit i covers data bits 8i+7:8i. On a read, `sd_dqm` is 0.
- R8: `sd_dq_in` is sampled 2 cycles (CAS latency) after the read command cycle. `rd_valid` pulses for one cycle, 3 cycles after the read command cycle, with that sampled word on `rd_data`. It never pulses at any other time.
- R9: Every 780 cycles (7.8 µs) the controller issues a precharge with A10 high and then an auto-refresh exactly 2 cycles later. Consecutive periodic refreshes are within 12 cycles of that interval.
- R10: A refresh comes at least 7 cycles after the last activate. `req_ready` is low from the refresh precharge until the row cycle time after the refresh, and no activate follows a refresh by fewer than 7 cycles.
- R11: While `rst_n` is low, the pins show no-operation, `sd_dq_oe` is 0, `req_ready` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 25 | {bank[1:0], row[12:0], column[9:0]} |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables for the write word |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_dqm | output | 2 | Per-byte data mask |
| sd_dq_out | output | 16 | Data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from the memory |

## Verification
A sequencer stuck in a wrong state shows at the pins on the very next command. It might put a read or write any number of cycles other than two after its activate, leave a stray command in a quiet slot, or break the power-up order. The bench catches any of these in the same cycle. A wrong gap load shows up as an activate or a refresh too close to the previous one, in the cycle where it appears. A refresh scheduler that loses its request shows up no more than 12 cycles past the expected interval. A read-capture pipeline with the wrong depth returns a word from the wrong cycle, so the valid pulse or the data mismatches three cycles after the read command.

// File: rtl/sdram_ctrl_pkg.sv
// Shared command encodings, sequencer states and cycle arithmetic for the
// SDRAM command and timing controller.
package sdram_ctrl_pkg;

    // Command word {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_RW,
        ST_RREF
    } seq_state_e;

    // Round a nanosecond limit up to whole clock cycles
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that spaces commands. Loading G-1 lets the next command go out
// G cycles after the one issued together with the load.
// Assumes every loaded gap is at least one cycle.
module sdram_gap_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count down to zero; reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_sched.sv
// Refresh interval counter. Raises a request every INTERVAL cycles and holds
// it until the sequencer acknowledges the refresh it issued.
// Assumes the acknowledge comes well inside one interval.
module sdram_refresh_sched #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt;

    // Free-running interval count and sticky request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else if (cnt == CW'(INTERVAL - 1)) begin
            cnt     <= '0;
            pending <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (ack)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_rd_capture.sv
// Read return path. A marker enters when a read command is issued, and the
// data bus is sampled CAS_LAT cycles after the command is on the pins.
// Assumes CAS_LAT >= 1 and single-word bursts.
module sdram_rd_capture #(
    parameter int CAS_LAT = 2,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [CAS_LAT:0] pipe;

    // Delay the read marker and capture the bus when it matures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pipe     <= {pipe[CAS_LAT-1:0], issue};
            rd_valid <= pipe[CAS_LAT];
            if (pipe[CAS_LAT])
                rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
// SDRAM command sequencer: power-up sequence, mode programming, closed-page
// reads/writes with auto-precharge, and scheduled auto-refresh.
// Assumes one rank, single-word bursts, and nanosecond limits converted to
// cycles of CLK_NS. All pin outputs are registered.
module sdram_seq_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int CLK_NS       = 10,
    parameter int T_RCD_NS     = 20,
    parameter int T_RP_NS      = 20,
    parameter int T_RRD_NS     = 20,
    parameter int T_RAS_NS     = 50,
    parameter int T_RC_NS      = 70,
    parameter int T_REFI_NS    = 7800,
    parameter int T_WREC_CLK   = 2,
    parameter int T_MRD_CLK    = 2,
    parameter int CAS_LAT      = 2,
    parameter int INIT_WAIT    = 20000,
    parameter int DATA_W       = 16,
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_write,
    input  logic [BANK_W+ROW_W+COL_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    input  logic [DATA_W/8-1:0]               req_be,
    output logic                              rd_valid,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              sd_cs_n,
    output logic                              sd_ras_n,
    output logic                              sd_cas_n,
    output logic                              sd_we_n,
    output logic [BANK_W-1:0]                 sd_ba,
    output logic [ROW_W-1:0]                  sd_addr,
    output logic [DATA_W/8-1:0]               sd_dqm,
    output logic [DATA_W-1:0]                 sd_dq_out,
    output logic                              sd_dq_oe,
    input  logic [DATA_W-1:0]                 sd_dq_in
);
    // Cycle counts derived from the nanosecond limits
    localparam int RCD      = ns_to_cyc(T_RCD_NS, CLK_NS);
    localparam int RP       = ns_to_cyc(T_RP_NS, CLK_NS);
    localparam int RRD      = ns_to_cyc(T_RRD_NS, CLK_NS);
    localparam int RAS      = ns_to_cyc(T_RAS_NS, CLK_NS);
    localparam int RC       = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int REFI     = ns_to_cyc(T_REFI_NS, CLK_NS);
    localparam int DAL      = T_WREC_CLK + RP;
    localparam int ACT_GAP  = max_int(max_int(RC, RAS + RP), max_int(RCD + DAL, RRD));
    localparam int POST_RW  = ACT_GAP - RCD;
    localparam int BYTES    = DATA_W / 8;
    localparam int AP_BIT   = 10;
    localparam int TMR_W    = $clog2(INIT_WAIT + ACT_GAP + RC + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'({3'(CAS_LAT), 1'b0, 3'b000});

    seq_state_e            state, nxt_state;
    sd_cmd_e               cmd_q, n_cmd;
    logic [BANK_W-1:0]     ba_q, n_ba;
    logic [ROW_W-1:0]      a_q, n_a;
    logic                  tmr_load, tmr_done;
    logic [TMR_W-1:0]      tmr_val;
    logic                  ref_pend, ref_ack;
    logic                  take, rd_issue, wr_issue;
    logic                  op_wr_q;
    logic [COL_W-1:0]      col_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [BYTES-1:0]      be_q;
    logic [DATA_W-1:0]     dq_out_q;
    logic                  oe_q;
    logic [BYTES-1:0]      dqm_q;

    sdram_gap_timer #(.W(TMR_W), .RST_VAL(INIT_WAIT - 1)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdram_refresh_sched #(.INTERVAL(REFI)) u_refsched (
        .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
    );

    sdram_rd_capture #(.CAS_LAT(CAS_LAT), .DW(DATA_W)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .issue(rd_issue), .dq_in(sd_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign req_ready = (state == ST_IDLE) && tmr_done && !ref_pend;

    // Choose the next command, its operands and the gap that follows it
    always_comb begin
        nxt_state = state;
        n_cmd     = CMD_NOP;
        n_ba      = ba_q;
        n_a       = a_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ref_ack   = 1'b0;
        take      = 1'b0;
        rd_issue  = 1'b0;
        wr_issue  = 1'b0;
        if (tmr_done) begin
            case (state)
                ST_BOOT: begin
                    n_cmd          = CMD_PRE;
                    n_a            = '0;
                    n_a[AP_BIT]    = 1'b1;
                    tmr_load       = 1'b1;
                    tmr_val        = TMR_W'(RP - 1);
                    nxt_state      = ST_IREF1;
                end
                ST_IREF1: begin
                    n_cmd     = CMD_REF;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RC - 1);
                    nxt_state = ST_IREF2;
                end
                ST_IREF2: begin
                    n_cmd     = CMD_REF;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RC - 1);
                    nxt_state = ST_IMRS;
                end
                ST_IMRS: begin
                    n_cmd     = CMD_MRS;
                    n_ba      = '0;
                    n_a       = MODE_WORD;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(T_MRD_CLK - 1);
                    nxt_state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        n_cmd       = CMD_PRE;
                        n_a         = '0;
                        n_a[AP_BIT] = 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = TMR_W'(RP - 1);
                        nxt_state   = ST_RREF;
                    end else if (req_valid) begin
                        take      = 1'b1;
                        n_cmd     = CMD_ACT;
                        n_ba      = req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
                        n_a       = req_addr[ROW_W+COL_W-1 -: ROW_W];
                        tmr_load  = 1'b1;
                        tmr_val   = TMR_W'(RCD - 1);
                        nxt_state = ST_RW;
                    end
                end
                ST_RW: begin
                    n_cmd              = op_wr_q ? CMD_WR : CMD_RD;
                    n_a                = '0;
                    n_a[COL_W-1:0]     = col_q;
                    n_a[AP_BIT]        = 1'b1;
                    wr_issue           = op_wr_q;
                    rd_issue           = !op_wr_q;
                    tmr_load           = 1'b1;
                    tmr_val            = TMR_W'(POST_RW - 1);
                    nxt_state          = ST_IDLE;
                end
                ST_RREF: begin
                    n_cmd     = CMD_REF;
                    ref_ack   = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(RC - 1);
                    nxt_state = ST_IDLE;
                end
                default: nxt_state = ST_BOOT;
            endcase
        end
    end

    // Advance the sequencer and register the pin outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_BOOT;
            cmd_q    <= CMD_NOP;
            ba_q     <= '0;
            a_q      <= '0;
            dq_out_q <= '0;
            oe_q     <= 1'b0;
            dqm_q    <= '0;
        end else begin
            state    <= nxt_state;
            cmd_q    <= n_cmd;
            ba_q     <= n_ba;
            a_q      <= n_a;
            dq_out_q <= wr_issue ? wdata_q : '0;
            oe_q     <= wr_issue;
            dqm_q    <= wr_issue ? ~be_q : '0;
        end
    end

    // Hold the accepted request's column, direction and write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            col_q   <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (take) begin
            op_wr_q <= req_write;
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_addr   = a_q;
    assign sd_dqm    = dqm_q;
    assign sd_dq_out = dq_out_q;
    assign sd_dq_oe  = oe_q;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
// Protocol checker for the command sequencer, attached through bind.
// Watches the pins and the host handshake only.
module sdram_seq_ctrl_chk
    import sdram_ctrl_pkg::*;
#(
    parameter int CAS_LAT = 2,
    parameter int RC_CYC  = 7
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ap_bit,
    input logic dq_oe,
    input logic req_ready,
    input logic rd_valid
);
    logic [3:0] c;
    logic       is_act, is_rd, is_wr, is_rw, is_mrs, is_ref, is_nop;
    logic [7:0] since_act;

    assign c      = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (c == CMD_ACT);
    assign is_rd  = (c == CMD_RD);
    assign is_wr  = (c == CMD_WR);
    assign is_rw  = is_rd || is_wr;
    assign is_mrs = (c == CMD_MRS);
    assign is_ref = (c == CMD_REF);
    assign is_nop = (c == CMD_NOP);

    // Cycles since the last activate on the pins, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_act <= 8'hFF;
        else if (is_act)
            since_act <= 8'd1;
        else if (since_act != 8'hFF)
            since_act <= since_act + 8'd1;
    end

    // R4
    act_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) is_act |=> is_nop);
    // R4
    rw_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n) is_rw |-> $past(is_act, 2));
    // R3
    rw_autopre_chk: assert property (@(posedge clk) disable iff (!rst_n) is_rw |-> ap_bit);
    // R6
    mrs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) is_mrs |=> is_nop);
    // R7
    oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> is_wr);
    // R7
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n) is_wr |-> dq_oe);
    // R8
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(is_rd, CAS_LAT + 1));
    // R10
    ref_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n) is_ref |-> (since_act >= 8'(RC_CYC)));
    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> is_nop);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(.CAS_LAT(CAS_LAT), .RC_CYC(RC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n),
    .we_n(sd_we_n), .ap_bit(sd_addr[10]), .dq_oe(sd_dq_oe), .req_ready(req_ready),
    .rd_valid(rd_valid)
);

// File: tb/sdram_seq_ctrl_test.sv
module sdram_seq_ctrl_test;
    import sdram_ctrl_pkg::*;

    localparam int INIT_W = 40;
    localparam int RCD_C  = 2;
    localparam int RP_C   = 2;
    localparam int RC_C   = 7;
    localparam int MRD_C  = 2;
    localparam int CL_C   = 2;
    localparam int REFI_C = 780;
    localparam int SLACK  = 12;

    typedef struct packed {
        logic        w;
        logic [24:0] a;
        logic [15:0] d;
        logic [1:0]  be;
    } req_t;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in = 16'hBEEF;

    sdram_seq_ctrl #(.INIT_WAIT(INIT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #2 clk = ~clk;

    int errs = 0, checks = 0, cyc = 0, rel_cyc = 1 << 30;
    int last_act = -1000, last_ref = -1000, last_pre = -1000, last_mrs = -1000;
    int last_pref = -1, init_step = 0, stall_until = -1, ref_cnt = 0;
    logic [12:0] open_row [4];
    logic [15:0] mem [int];
    req_t exp_q[$];
    req_t cur;
    int rd_due[$], dq_due[$];
    logic [15:0] rd_val[$], dq_val[$];
    logic [3:0] cmd;
    int key;
    logic [15:0] v;
    bit exp_v;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] mem_rd(input int k);
        if (mem.exists(k)) return mem[k];
        return k[15:0] ^ 16'h5A3C;
    endfunction

    // Behavioural reference model, evaluated every clock away from the edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            // R11 reset state
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP, "R11 pins NOP in reset",
                32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(CMD_NOP));
            chk(!req_ready && !rd_valid && !sd_dq_oe, "R11 ready/valid/oe low in reset",
                32'({req_ready, rd_valid, sd_dq_oe}), 0);
        end else begin
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (dq_due.size() > 0 && dq_due[0] == cyc) begin
                sd_dq_in = dq_val[0];
                void'(dq_due.pop_front());
                void'(dq_val.pop_front());
            end else sd_dq_in = 16'hBEEF;
            exp_v = rd_due.size() > 0 && rd_due[0] == cyc;
            chk(rd_valid == exp_v, "R8 rd_valid timing", 32'(rd_valid), 32'(exp_v));
            if (exp_v) begin
                chk(rd_data == rd_val[0], "R8 read data", 32'(rd_data), 32'(rd_val[0]));
                void'(rd_due.pop_front());
                void'(rd_val.pop_front());
            end
            if (cmd != CMD_WR) chk(!sd_dq_oe, "R7 oe only on write", 32'(sd_dq_oe), 0);
            if (init_step < 4) chk(!req_ready, "R1 ready low during init", 32'(req_ready), 0);
            if (cyc <= stall_until) chk(!req_ready, "R10 ready low around refresh", 32'(req_ready), 0);
            if (cmd != CMD_NOP) begin
                chk(cmd inside {CMD_MRS, CMD_REF, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE},
                    "R2 legal command code", 32'(cmd), 32'(CMD_NOP));
                chk(cyc - last_mrs >= MRD_C, "R6 quiet after mode set", 32'(cyc - last_mrs), MRD_C);
            end
            if (init_step < 4 && cmd != CMD_NOP) begin
                case (init_step)
                    0: begin
                        chk(cmd == CMD_PRE && sd_addr[10], "R1 first command precharge-all",
                            32'({cmd, sd_addr[10]}), 32'({CMD_PRE, 1'b1}));
                        chk(cyc - rel_cyc >= INIT_W, "R1 stable wait", 32'(cyc - rel_cyc), INIT_W);
                        last_pre = cyc;
                    end
                    1: begin
                        chk(cmd == CMD_REF && cyc - last_pre == RP_C, "R1 first refresh",
                            32'(cyc - last_pre), RP_C);
                        last_ref = cyc;
                    end
                    2: begin
                        chk(cmd == CMD_REF && cyc - last_ref == RC_C, "R1 second refresh",
                            32'(cyc - last_ref), RC_C);
                        last_ref = cyc;
                    end
                    default: begin
                        chk(cmd == CMD_MRS && cyc - last_ref == RC_C, "R1 mode set timing",
                            32'(cyc - last_ref), RC_C);
                        chk(sd_addr == 13'h020 && sd_ba == 2'b00, "R1 mode word",
                            32'({sd_ba, sd_addr}), 32'h020);
                        last_mrs = cyc;
                    end
                endcase
                init_step++;
            end else if (cmd != CMD_NOP) begin
                case (cmd)
                    CMD_PRE: begin
                        chk(sd_addr[10], "R9 refresh precharge closes all", 32'(sd_addr[10]), 1);
                        chk(cyc - last_act >= RC_C, "R10 precharge after row cycle", 32'(cyc - last_act), RC_C);
                        last_pre = cyc;
                        stall_until = cyc + RP_C + RC_C - 2;
                    end
                    CMD_REF: begin
                        chk(cyc - last_pre == RP_C, "R9 refresh after precharge", 32'(cyc - last_pre), RP_C);
                        chk(cyc - last_act >= RC_C, "R10 refresh after activate", 32'(cyc - last_act), RC_C);
                        if (last_pref < 0)
                            chk(cyc - rel_cyc <= REFI_C + SLACK, "R9 first periodic refresh",
                                32'(cyc - rel_cyc), REFI_C);
                        else
                            chk(cyc - last_pref >= REFI_C - SLACK && cyc - last_pref <= REFI_C + SLACK,
                                "R9 refresh interval", 32'(cyc - last_pref), REFI_C);
                        last_pref = cyc;
                        last_ref = cyc;
                        ref_cnt++;
                    end
                    CMD_ACT: begin
                        chk(cyc - last_act >= RC_C, "R5 activate spacing", 32'(cyc - last_act), RC_C);
                        chk(cyc - last_ref >= RC_C, "R10 activate after refresh", 32'(cyc - last_ref), RC_C);
                        chk(exp_q.size() > 0, "R3 activate without request", 32'(exp_q.size()), 1);
                        if (exp_q.size() > 0) begin
                            cur = exp_q.pop_front();
                            chk(sd_ba == cur.a[24:23], "R3 bank on activate", 32'(sd_ba), 32'(cur.a[24:23]));
                            chk(sd_addr == cur.a[22:10], "R3 row on activate", 32'(sd_addr), 32'(cur.a[22:10]));
                        end
                        open_row[sd_ba] = sd_addr;
                        last_act = cyc;
                    end
                    CMD_RD, CMD_WR: begin
                        chk(cyc - last_act == RCD_C, "R4 activate to column", 32'(cyc - last_act), RCD_C);
                        chk(sd_addr[10], "R3 auto-precharge flag", 32'(sd_addr[10]), 1);
                        chk(cmd == (cur.w ? CMD_WR : CMD_RD), "R3 direction", 32'(cmd),
                            32'(cur.w ? CMD_WR : CMD_RD));
                        chk(sd_ba == cur.a[24:23] && sd_addr[9:0] == cur.a[9:0], "R3 bank/column",
                            32'({sd_ba, sd_addr[9:0]}), 32'({cur.a[24:23], cur.a[9:0]}));
                        key = int'({sd_ba, open_row[sd_ba], sd_addr[9:0]});
                        if (cmd == CMD_WR) begin
                            chk(sd_dq_oe && sd_dq_out == cur.d, "R7 write data",
                                32'({sd_dq_oe, sd_dq_out}), 32'({1'b1, cur.d}));
                            chk(sd_dqm == ~cur.be, "R7 write mask", 32'(sd_dqm), 32'(~cur.be));
                            v = mem_rd(key);
                            if (!sd_dqm[0]) v[7:0] = sd_dq_out[7:0];
                            if (!sd_dqm[1]) v[15:8] = sd_dq_out[15:8];
                            mem[key] = v;
                        end else begin
                            chk(sd_dqm == 2'b00, "R7 read mask", 32'(sd_dqm), 0);
                            v = mem_rd(key);
                            dq_due.push_back(cyc + CL_C);
                            dq_val.push_back(v);
                            rd_due.push_back(cyc + CL_C + 1);
                            rd_val.push_back(v);
                        end
                    end
                    default: chk(1'b0, "R2 unexpected command after init", 32'(cmd), 32'(CMD_NOP));
                endcase
            end
        end
    end

    task automatic do_req(input bit w, input logic [24:0] a, input logic [15:0] d, input logic [1:0] be);
        req_write = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back('{w: w, a: a, d: d, be: be});
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    function automatic logic [24:0] mk_addr(input int i);
        return {2'(i), 13'(i * 37 + 5), 10'(i * 13 + 1)};
    endfunction

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        rel_cyc = cyc;
        wait (init_step == 4);
        // R3/R7 full writes across all banks, then read back (R8)
        for (int i = 0; i < 40; i++) do_req(1'b1, mk_addr(i), 16'(i * 911 + 17), 2'b11);
        for (int i = 0; i < 40; i++) do_req(1'b0, mk_addr(i), 16'h0, 2'b00);
        // R7 byte-masked writes and read-back of the merged word
        for (int i = 0; i < 8; i++) begin
            do_req(1'b1, mk_addr(i), 16'hFFFF, 2'b01);
            do_req(1'b1, mk_addr(i + 8), 16'h0000, 2'b10);
            do_req(1'b0, mk_addr(i), 16'h0, 2'b00);
            do_req(1'b0, mk_addr(i + 8), 16'h0, 2'b00);
        end
        // R8 reads of never-written locations
        for (int i = 200; i < 206; i++) do_req(1'b0, mk_addr(i), 16'h0, 2'b00);
        // Mixed traffic across refresh boundaries (R9, R10)
        for (int i = 0; i < 150; i++)
            do_req(i[0], mk_addr(i % 23), 16'(i * 77), 2'(i % 3 + 1));
        repeat (2 * REFI_C + 100) @(negedge clk);
        chk(ref_cnt >= 3, "R9 periodic refresh count", 32'(ref_cnt), 3);
        chk(rd_due.size() == 0 && exp_q.size() == 0, "R8 all reads returned",
            32'(rd_due.size() + exp_q.size()), 0);
        finish_run();
    end
endmodule